// File: doc/BRIEF.md
# External Sample-Rate Meter

This block estimates the frame rate of a digital audio input by counting cycles of a 28.224 MHz reference clock across one frame period. Two audio inputs are wired in. A select bit chooses which one is measured. Each input's frame clock is asynchronous to the reference. It is brought into the reference domain by a two-stage synchroniser, followed by a rising-edge detector that emits a one-cycle period marker.

The block latches a result when the host pulses a save strobe. The result has two parts:
- the raw period, as a 10-bit tick count that saturates at full scale;
- a 4-bit code naming the standard audio rate nearest the measurement.

Snapping uses no divider. The tick count is compared with fifteen tick limits, and each limit is worked out at elaboration from a rate threshold. A longer period means a lower rate. The code is forced to zero when either the clock-present flag or the data-present flag of the chosen input is low. A valid flag shows that the selection has been stable for long enough to trust a result: two periods of the slowest rate (8 kHz), which is 7056 reference cycles.

Top module: `ext_rate_meter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ticks_o` and `rate_code_o` are 0 and `valid_o` is low.
- R2: After a save pulse, `ticks_o` holds the number of reference cycles between the two latest rising edges of the selected frame clock.
- R3: A period of 1023 cycles or more is reported as 1023. The counter stops at 1023 and does not wrap.
- R4: The rate code is the count of tick limits that the tick count does not exceed, in the range 0..15.
  - Codes 1..15 stand for 8000, 11025, 12000, 16000, 22050, 24000, 32000, 44100, 48000, 64000, 88200, 96000, 128000, 176400 and 192000 Hz, in that order.
  - With the default parameters the tick limits for codes 6..15 are 1225, 1007, 741, 612, 503, 370, 306, 251, 185 and 153.
  - For example, 153 ticks gives 15 and 154 gives 14; 1007 gives 7 and 1008 gives 6.
- R5: If the clock-present flag or the data-present flag of the selected input is low at the save pulse, the latched `rate_code_o` is 0. `ticks_o` still takes the raw count.
- R6: A change of `src_sel_i` clears the stored period to 0 and restarts the count. It drives `valid_o` low on the next cycle. The first partial period after the change is discarded.
- R7: `valid_o` goes high once `src_sel_i` has been unchanged for `SETTLE_CYC` (default 7056) reference cycles since reset or since the last change.
- R8: Without a save pulse, `ticks_o` and `rate_code_o` keep their values while the input period changes.
- R9: A tick count of 0 (no complete period seen) yields rate code 0.
- R10: The frame clock and the presence flags of the input that is not selected have no effect on the saved result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 28.224 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk_i | input | N_IN | Frame clocks of the audio inputs, asynchronous |
| clk_ok_i | input | N_IN | Clock-present flag per input, reference domain |
| data_ok_i | input | N_IN | Data-present flag per input, reference domain |
| src_sel_i | input | SEL_W | Index of the input to measure |
| save_i | input | 1 | Latch strobe for the result |
| ticks_o | output | TICK_W | Latched period in reference ticks |
| rate_code_o | output | 4 | Latched standard-rate code, 0 = none |
| valid_o | output | 1 | Selection stable for the settle interval |

## Verification
The snap ladder is driven with frame periods that sit on each side of several tick limits: 153/154, 612/613 and 1007/1008. Periods at the nominal rates are also driven. Together these separate an off-by-one in a limit or a `<` versus `<=` comparison from a wrong code order. A period of 2000 cycles checks saturation against wrap-around. A selected input with no frame clock checks the zero-tick path, and a change of selection separates the cleared state from stale data. Presence flags are dropped one at a time on the selected input and both at once on the other input, which tells correct gating from gating on the wrong index.

// File: rtl/ext_rate_meter_pkg.sv
package ext_rate_meter_pkg;

  localparam int unsigned N_RATES = 15;
  localparam int unsigned CODE_W  = 4;

  // Lower bound in Hz (exclusive) of each rate code, ascending by code.
  function automatic longint unsigned rate_floor_hz(input int unsigned code);
    case (code)
      1:       return 64'd7000;
      2:       return 64'd9512;
      3:       return 64'd11512;
      4:       return 64'd14000;
      5:       return 64'd19025;
      6:       return 64'd23025;
      7:       return 64'd28000;
      8:       return 64'd38050;
      9:       return 64'd46050;
      10:      return 64'd56000;
      11:      return 64'd76100;
      12:      return 64'd92100;
      13:      return 64'd112000;
      14:      return 64'd152200;
      default: return 64'd184200;
    endcase
  endfunction

  // floor(ref/t) > f  <=>  t <= floor(ref/(f+1))
  function automatic longint unsigned tick_limit(input longint unsigned ref_hz,
                                                 input int unsigned code);
    return ref_hz / (rate_floor_hz(code) + 64'd1);
  endfunction

endpackage

// File: rtl/erm_edge_sync.sv
module erm_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/erm_period_meter.sv
module erm_period_meter #(
  parameter int unsigned TICK_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              mark_i,
  output logic [TICK_W-1:0] meas_o
);
  localparam logic [TICK_W-1:0] MAX = {TICK_W{1'b1}};

  logic [TICK_W-1:0] cnt_q;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      meas_o  <= '0;
    end else if (mark_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      if (armed_q) meas_o <= (cnt_q == MAX) ? MAX : cnt_q + 1'b1;
    end else if (cnt_q != MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: a full counter stays full until a marker or restart
  assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAX && !mark_i && !restart_i) |=> cnt_q == MAX);
  // R6: restart clears the stored period and disarms
  assert_restart_clr_R6: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (meas_o == '0 && !armed_q));
  // R6: first marker after restart does not latch
  assert_first_skip_R6: assert property (@(posedge clk) disable iff (rst)
    (mark_i && !armed_q && !restart_i) |=> $stable(meas_o));
endmodule

// File: rtl/erm_rate_snap.sv
module erm_rate_snap
  import ext_rate_meter_pkg::*;
#(
  parameter int unsigned     TICK_W = 10,
  parameter longint unsigned REF_HZ = 28224000
) (
  input  logic [TICK_W-1:0] ticks_i,
  output logic [CODE_W-1:0] code_o
);
  logic [N_RATES-1:0] hit;
  logic [63:0]        ticks_w;

  assign ticks_w = {{(64-TICK_W){1'b0}}, ticks_i};

  for (genvar k = 0; k < N_RATES; k++) begin : g_cmp
    localparam logic [63:0] LIM = tick_limit(REF_HZ, k + 1);
    assign hit[k] = (ticks_w <= LIM);
  end

  always_comb begin
    if (ticks_i == '0) code_o = '0;
    else               code_o = CODE_W'($countones(hit));
  end
endmodule

// File: rtl/ext_rate_meter.sv
module ext_rate_meter
  import ext_rate_meter_pkg::*;
#(
  parameter int unsigned     N_IN       = 2,
  parameter int unsigned     TICK_W     = 10,
  parameter longint unsigned REF_HZ     = 28224000,
  parameter int unsigned     SETTLE_CYC = 7056,
  localparam int unsigned    SEL_W      = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   frame_clk_i,
  input  logic [N_IN-1:0]   clk_ok_i,
  input  logic [N_IN-1:0]   data_ok_i,
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic              save_i,
  output logic [TICK_W-1:0] ticks_o,
  output logic [3:0]        rate_code_o,
  output logic              valid_o
);
  localparam int unsigned SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SET_END = SET_W'(SETTLE_CYC);

  logic [N_IN-1:0]   rise;
  logic [SEL_W-1:0]  sel_q;
  logic              chg;
  logic              present;
  logic [TICK_W-1:0] meas;
  logic [CODE_W-1:0] snap_code;
  logic [SET_W-1:0]  settle_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    erm_edge_sync u_sync (
      .clk    (clk),
      .rst    (rst),
      .async_i(frame_clk_i[i]),
      .rise_o (rise[i])
    );
  end

  assign chg     = (src_sel_i != sel_q);
  assign present = clk_ok_i[src_sel_i] & data_ok_i[src_sel_i];

  erm_period_meter #(.TICK_W(TICK_W)) u_period (
    .clk      (clk),
    .rst      (rst),
    .restart_i(chg),
    .mark_i   (rise[src_sel_i]),
    .meas_o   (meas)
  );

  erm_rate_snap #(.TICK_W(TICK_W), .REF_HZ(REF_HZ)) u_snap (
    .ticks_i(meas),
    .code_o (snap_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      settle_q <= '0;
      valid_o  <= 1'b0;
    end else begin
      sel_q <= src_sel_i;
      if (chg) begin
        settle_q <= '0;
        valid_o  <= 1'b0;
      end else begin
        if (settle_q != SET_END) settle_q <= settle_q + 1'b1;
        valid_o <= (settle_q == SET_END);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks_o     <= '0;
      rate_code_o <= '0;
    end else if (save_i) begin
      ticks_o     <= meas;
      rate_code_o <= present ? 4'(snap_code) : 4'd0;
    end
  end

  // R8: outputs only move on a save pulse
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !save_i |=> ($stable(ticks_o) && $stable(rate_code_o)));
  // R5: missing presence flag forces code 0
  assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (save_i && !present) |=> rate_code_o == 4'd0);
  // R9: zero ticks give code 0
  assert_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (save_i && meas == '0) |=> rate_code_o == 4'd0);
  // R6: selection change drops valid
  assert_sel_drop_R6: assert property (@(posedge clk) disable iff (rst)
    chg |=> !valid_o);
  // R7: valid rises only after the full settle interval
  assert_settle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> settle_q == SET_END);
endmodule

// File: tb/ext_rate_meter_tb_top.sv
module ext_rate_meter_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] frame_clk;
  logic [1:0] clk_ok;
  logic [1:0] data_ok;
  logic       src_sel;
  logic       save;
  logic [9:0] ticks;
  logic [3:0] rate_code;
  logic       valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int per [2];
  int fc  [2];

  always #2.5 clk = ~clk;

  ext_rate_meter dut_i (
    .clk        (clk),
    .rst        (rst),
    .frame_clk_i(frame_clk),
    .clk_ok_i   (clk_ok),
    .data_ok_i  (data_ok),
    .src_sel_i  (src_sel),
    .save_i     (save),
    .ticks_o    (ticks),
    .rate_code_o(rate_code),
    .valid_o    (valid)
  );

  // frame clock generators, one rising edge every per[i] cycles
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (per[i] == 0) begin
        frame_clk[i] = 1'b0;
      end else begin
        fc[i] = (fc[i] + 1 >= per[i]) ? 0 : fc[i] + 1;
        frame_clk[i] = (fc[i] < per[i] / 2);
      end
    end
  end

  // period, expected code
  localparam int VEC [16][2] = '{
    '{147, 15}, '{153, 15}, '{154, 14}, '{160, 14},
    '{220, 13}, '{294, 12}, '{320, 11}, '{441, 10},
    '{588, 9},  '{612, 9},  '{613, 8},  '{640, 8},
    '{882, 7},  '{1007, 7}, '{1008, 6}, '{2000, 6}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_save();
    @(negedge clk) save = 1'b1;
    @(negedge clk) save = 1'b0;
  endtask

  task automatic settle_period(input int p);
    wait_cyc(4 * p + 20);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 5);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    per[0] = 441; per[1] = 0; fc[0] = 0; fc[1] = 0;
    frame_clk = 2'b00;
    rst = 1'b1; clk_ok = 2'b11; data_ok = 2'b11;
    src_sel = 1'b0; save = 1'b0;
    wait_cyc(5);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ticks", ticks, 0);
    chk("R1 code", rate_code, 0);
    chk("R1 valid", valid, 0);

    wait_cyc(100);
    chk("R7 valid early", valid, 0);
    wait_cyc(7100);
    chk("R7 valid after settle", valid, 1);

    // main ladder: R2 period, R3 saturation, R4 code
    for (int v = 0; v < 16; v++) begin
      per[0] = VEC[v][0];
      settle_period(VEC[v][0]);
      do_save();
      chk("R2/R3 ticks", ticks, (VEC[v][0] > 1023) ? 1023 : VEC[v][0]);
      chk("R4 code", rate_code, VEC[v][1]);
    end

    // R8: no save, outputs hold
    per[0] = 294;
    settle_period(294);
    chk("R8 ticks hold", ticks, 1023);
    chk("R8 code hold", rate_code, 6);
    do_save();
    chk("R8 ticks after save", ticks, 294);
    chk("R8 code after save", rate_code, 12);

    // R10: unselected input ignored
    per[0] = 441;
    per[1] = 150;
    clk_ok[1] = 1'b0; data_ok[1] = 1'b0;
    settle_period(441);
    do_save();
    chk("R10 ticks", ticks, 441);
    chk("R10 code", rate_code, 10);
    clk_ok[1] = 1'b1; data_ok[1] = 1'b1;

    // R5: presence gating
    data_ok[0] = 1'b0;
    do_save();
    chk("R5 data missing code", rate_code, 0);
    chk("R5 raw ticks kept", ticks, 441);
    data_ok[0] = 1'b1; clk_ok[0] = 1'b0;
    do_save();
    chk("R5 clock missing code", rate_code, 0);
    clk_ok[0] = 1'b1;
    do_save();
    chk("R5 restored code", rate_code, 10);

    // R6 / R9: select input 1 that has no frame clock
    per[1] = 0;
    wait_cyc(10);
    @(negedge clk) src_sel = 1'b1;
    @(negedge clk);
    chk("R6 valid drop", valid, 0);
    do_save();
    chk("R6 ticks cleared", ticks, 0);
    chk("R9 code zero", rate_code, 0);
    wait_cyc(7200);
    chk("R7 valid on new input", valid, 1);
    do_save();
    chk("R9 no markers ticks", ticks, 0);
    chk("R9 no markers code", rate_code, 0);
    per[1] = 160;
    settle_period(160);
    do_save();
    chk("R6 new input ticks", ticks, 160);
    chk("R6 new input code", rate_code, 14);

    finish_run();
  end
endmodule